// File: doc/BRIEF.md
# Responder Mailbox Register File with Completion Alert

This block is the responder end of a byte-wide management mailbox. An external initiator reaches a small set of 8-bit registers through a plain port with an address, write data, a write strobe and a read strobe. That port takes the place of a byte-data serial front end. The initiator loads a command byte and a 32-bit argument into the inbound message bytes. It can tag the message as pending. It then rings a doorbell by writing the trigger value to the software-interrupt register.

Firmware sits on a second port. It sees the inbound bytes, a decoded command and argument, and a one-cycle doorbell pulse. When firmware finishes, it places its result in the outbound message bytes and strobes completion. Completion sets a sticky alert status bit, and the initiator clears that bit by writing a 1 to it. The alert output follows the status bit unless a mask bit in the control register is set. Out of reset the mask bit is set.

Top module: `mbox_responder`

## Requirements
- R1: After reset the control register reads 0x10 and the status register reads 0x00. Every inbound and outbound message byte reads 0x00, and alert and doorbell are low.
- R2: The control register sits at address 0x01 and stores all 8 written bits. A read strobe in one cycle loads host_rdata at that clock edge. host_rdata then holds until the next read strobe.
- R3: Inbound bytes 0..7 sit at addresses 0x38..0x3F, and the initiator can read and write them. Firmware receives byte 0 as fw_cmd and bytes 1..4 as fw_arg, with the least significant byte at 0x39. fw_pending is high while byte 7 (address 0x3F) equals 0x80.
- R4: Outbound bytes 0..7 sit at addresses 0x30..0x37. Only firmware writes them, either by byte index or as a 32-bit word into bytes 1..4 with the least significant byte at 0x31. Initiator writes to 0x30..0x37 leave them unchanged.
- R5: An initiator write of exactly 0x01 to address 0x40 produces fw_doorbell high for exactly the one cycle after the write edge. A write of any other value to 0x40 produces no pulse.
- R6: Address 0x40 reads back 0x00 once the doorbell pulse has been issued.
- R7: Status bit 1 (address 0x02) is set by fw_done and stays set until the initiator writes 0x02 there with bit 1 high. A write with bit 1 low has no effect. All other status bits read 0.
- R8: If fw_done and an initiator clear of status bit 1 fall in the same cycle, the bit stays set.
- R9: alert is high exactly while status bit 1 is set and control bit 4 is 0.
- R10: Addresses outside 0x01, 0x02, 0x30..0x40 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Initiator register address |
| host_wdata | input | 8 | Initiator write data |
| host_we | input | 1 | Initiator write strobe |
| host_re | input | 1 | Initiator read strobe |
| host_rdata | output | 8 | Read data, loaded at the edge that samples host_re |
| alert | output | 1 | Completion alert, active high |
| fw_doorbell | output | 1 | One-cycle command pulse to firmware |
| fw_cmd | output | 8 | Inbound byte 0 |
| fw_arg | output | 32 | Inbound bytes 4..1 |
| fw_pending | output | 1 | Inbound byte 7 holds the pending mark 0x80 |
| fw_out_we | input | 1 | Firmware single-byte outbound write |
| fw_out_idx | input | 3 | Outbound byte index for fw_out_we |
| fw_out_byte | input | 8 | Outbound byte value |
| fw_res_we | input | 1 | Firmware 32-bit result write into outbound bytes 1..4 |
| fw_res_word | input | 32 | Result word, least significant byte to byte 1 |
| fw_done | input | 1 | Firmware completion strobe |

## Verification
The inbound and outbound paths are driven with words whose four bytes all differ, such as 0x12345678 and 0xCAFEF00D. Any swap of byte order or misplaced base address therefore shows up as a wrong byte at a known address. The doorbell is written first with 0x03 and then with 0x01, which separates an exact-value match from a test of the low bit only. The status bit is cleared once with bit 1 low and once with bit 1 high, and once at the same time as completion. These cases separate write-1-to-clear from plain write and set priority from clear priority. The alert is observed with the mask set and then cleared, which shows that the mask gates the output.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MSG_BYTES = 8;
    localparam int unsigned IDX_W     = $clog2(MSG_BYTES);
    localparam int unsigned WORD_W    = 32;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t ADDR_CTRL     = 8'h01;
    localparam byte_t ADDR_STAT     = 8'h02;
    localparam byte_t ADDR_OUT_BASE = 8'h30;
    localparam byte_t ADDR_IN_BASE  = 8'h38;
    localparam byte_t ADDR_SWI      = 8'h40;
    localparam byte_t ADDR_OUT_END  = ADDR_OUT_BASE + byte_t'(MSG_BYTES);
    localparam byte_t ADDR_IN_END   = ADDR_IN_BASE + byte_t'(MSG_BYTES);

    localparam byte_t CTRL_RESET    = 8'h10;
    localparam int unsigned CTRL_MASK_BIT  = 4;
    localparam int unsigned STAT_ALERT_BIT = 1;
    localparam byte_t SWI_GO        = 8'h01;
    localparam byte_t PEND_MARK     = 8'h80;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_OUT,
        SEL_IN,
        SEL_SWI
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic decode_t decode_addr(input byte_t a);
        decode_t d;
        byte_t   off;
        d.sel = SEL_NONE;
        d.idx = '0;
        off   = '0;
        if (a == ADDR_CTRL) begin
            d.sel = SEL_CTRL;
        end else if (a == ADDR_STAT) begin
            d.sel = SEL_STAT;
        end else if (a == ADDR_SWI) begin
            d.sel = SEL_SWI;
        end else if (a >= ADDR_OUT_BASE && a < ADDR_OUT_END) begin
            off   = a - ADDR_OUT_BASE;
            d.sel = SEL_OUT;
            d.idx = off[IDX_W-1:0];
        end else if (a >= ADDR_IN_BASE && a < ADDR_IN_END) begin
            off   = a - ADDR_IN_BASE;
            d.sel = SEL_IN;
            d.idx = off[IDX_W-1:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/mbox_ctrl_status.sv
module mbox_ctrl_status
    import mbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_we,
    input  logic  stat_we,
    input  byte_t wdata,
    input  logic  fw_done,
    output byte_t ctrl_q,
    output byte_t stat_rd,
    output logic  alert
);

    logic sts_q;
    logic clr_req;

    assign clr_req = stat_we && wdata[STAT_ALERT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_we) begin
            ctrl_q <= wdata;
        end
    end

    // completion takes priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
        end else if (fw_done) begin
            sts_q <= 1'b1;
        end else if (clr_req) begin
            sts_q <= 1'b0;
        end
    end

    always_comb begin
        stat_rd = '0;
        stat_rd[STAT_ALERT_BIT] = sts_q;
    end

    assign alert = sts_q && !ctrl_q[CTRL_MASK_BIT];

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (ctrl_q == CTRL_RESET && !sts_q)); // R1

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_q && !clr_req) |=> sts_q); // R7

    AST_DONE_WINS: assert property (@(posedge clk) disable iff (rst)
        (fw_done && clr_req) |=> sts_q); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !fw_done) |=> !sts_q); // R7

endmodule

// File: rtl/mbox_msg_bank.sv
module mbox_msg_bank
    import mbox_pkg::*;
#(
    parameter int unsigned N_BYTES = MSG_BYTES,
    parameter int unsigned IW      = IDX_W,
    parameter int unsigned WW      = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_in_we,
    input  logic [IW-1:0]        host_idx,
    input  byte_t                host_wdata,
    input  logic                 fw_out_we,
    input  logic [IW-1:0]        fw_out_idx,
    input  byte_t                fw_out_byte,
    input  logic                 fw_res_we,
    input  logic [WW-1:0]        fw_res_word,
    output logic [N_BYTES-1:0][BYTE_W-1:0] in_q,
    output logic [N_BYTES-1:0][BYTE_W-1:0] out_q
);

    localparam int unsigned WORD_BYTES = WW / BYTE_W;
    localparam int unsigned WORD_LO    = 1;
    localparam int unsigned WORD_HI    = WORD_LO + WORD_BYTES - 1;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                in_q[i] <= '0;
            end else if (host_in_we && host_idx == IW'(i)) begin
                in_q[i] <= host_wdata;
            end
        end

        if (i >= WORD_LO && i <= WORD_HI) begin : g_word_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q[i] <= '0;
                end else if (fw_res_we) begin
                    out_q[i] <= fw_res_word[BYTE_W*(i-WORD_LO) +: BYTE_W];
                end else if (fw_out_we && fw_out_idx == IW'(i)) begin
                    out_q[i] <= fw_out_byte;
                end
            end
        end else begin : g_plain_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q[i] <= '0;
                end else if (fw_out_we && fw_out_idx == IW'(i)) begin
                    out_q[i] <= fw_out_byte;
                end
            end
        end
    end

    AST_OUT_HOST_RO: assert property (@(posedge clk) disable iff (rst)
        (!fw_out_we && !fw_res_we) |=> $stable(out_q)); // R4

    AST_IN_FW_RO: assert property (@(posedge clk) disable iff (rst)
        !host_in_we |=> $stable(in_q)); // R3

endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
    import mbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  swi_we,
    input  byte_t wdata,
    output logic  doorbell,
    output byte_t swi_rd
);

    logic trig_q;

    // trigger bit lives one cycle: it is the pulse and clears itself
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= swi_we && (wdata == SWI_GO);
        end
    end

    assign doorbell = trig_q;
    assign swi_rd   = {{(BYTE_W-1){1'b0}}, trig_q};

    AST_DB_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(doorbell) |-> $past(swi_we && wdata == SWI_GO)); // R5

    AST_DB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (doorbell && !(swi_we && wdata == SWI_GO)) |=> !doorbell); // R5

    AST_DB_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        (swi_we && wdata != SWI_GO) |=> !doorbell); // R5

endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
    import mbox_pkg::*;
#(
    parameter int unsigned N_BYTES = MSG_BYTES,
    parameter int unsigned IW      = IDX_W,
    parameter int unsigned WW      = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          host_we,
    input  logic          host_re,
    output logic [7:0]    host_rdata,
    output logic          alert,
    output logic          fw_doorbell,
    output logic [7:0]    fw_cmd,
    output logic [WW-1:0] fw_arg,
    output logic          fw_pending,
    input  logic          fw_out_we,
    input  logic [IW-1:0] fw_out_idx,
    input  logic [7:0]    fw_out_byte,
    input  logic          fw_res_we,
    input  logic [WW-1:0] fw_res_word,
    input  logic          fw_done
);

    localparam int unsigned WORD_BYTES = WW / BYTE_W;
    localparam int unsigned PEND_IDX   = N_BYTES - 1;

    decode_t dec;
    byte_t   ctrl_q;
    byte_t   stat_rd;
    byte_t   swi_rd;
    byte_t   rd_mux;
    byte_t   rdata_q;
    logic    alert_w;
    logic    doorbell_w;
    logic [N_BYTES-1:0][BYTE_W-1:0] in_q;
    logic [N_BYTES-1:0][BYTE_W-1:0] out_q;

    assign dec = decode_addr(host_addr);

    mbox_ctrl_status u_cs (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (host_we && dec.sel == SEL_CTRL),
        .stat_we (host_we && dec.sel == SEL_STAT),
        .wdata   (host_wdata),
        .fw_done (fw_done),
        .ctrl_q  (ctrl_q),
        .stat_rd (stat_rd),
        .alert   (alert_w)
    );

    mbox_msg_bank #(
        .N_BYTES (N_BYTES),
        .IW      (IW),
        .WW      (WW)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .host_in_we  (host_we && dec.sel == SEL_IN),
        .host_idx    (dec.idx),
        .host_wdata  (host_wdata),
        .fw_out_we   (fw_out_we),
        .fw_out_idx  (fw_out_idx),
        .fw_out_byte (fw_out_byte),
        .fw_res_we   (fw_res_we),
        .fw_res_word (fw_res_word),
        .in_q        (in_q),
        .out_q       (out_q)
    );

    mbox_doorbell u_db (
        .clk      (clk),
        .rst      (rst),
        .swi_we   (host_we && dec.sel == SEL_SWI),
        .wdata    (host_wdata),
        .doorbell (doorbell_w),
        .swi_rd   (swi_rd)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_STAT: rd_mux = stat_rd;
            SEL_SWI:  rd_mux = swi_rd;
            SEL_OUT:  rd_mux = out_q[dec.idx];
            SEL_IN:   rd_mux = in_q[dec.idx];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (host_re) begin
            rdata_q <= rd_mux;
        end
    end

    always_comb begin
        fw_arg = '0;
        for (int b = 0; b < WORD_BYTES; b++) begin
            fw_arg[BYTE_W*b +: BYTE_W] = in_q[b+1];
        end
    end

    assign host_rdata  = rdata_q;
    assign alert       = alert_w;
    assign fw_doorbell = doorbell_w;
    assign fw_cmd      = in_q[0];
    assign fw_pending  = (in_q[PEND_IDX] == PEND_MARK);

    AST_ALERT_MASKED: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[CTRL_MASK_BIT] |-> !alert); // R9

    AST_ALERT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        alert |-> stat_rd[STAT_ALERT_BIT]); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_re && dec.sel == SEL_NONE) |=> (host_rdata == 8'h00)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !host_re |=> $stable(host_rdata)); // R2

endmodule

// File: tb/mbox_responder_bench.sv
module mbox_responder_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [7:0]  host_rdata;
    logic        alert;
    logic        fw_doorbell;
    logic [7:0]  fw_cmd;
    logic [31:0] fw_arg;
    logic        fw_pending;
    logic        fw_out_we = 1'b0;
    logic [2:0]  fw_out_idx = '0;
    logic [7:0]  fw_out_byte = '0;
    logic        fw_res_we = 1'b0;
    logic [31:0] fw_res_word = '0;
    logic        fw_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mbox_responder u_mbox_responder (
        .clk         (clk),
        .rst         (rst),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_we     (host_we),
        .host_re     (host_re),
        .host_rdata  (host_rdata),
        .alert       (alert),
        .fw_doorbell (fw_doorbell),
        .fw_cmd      (fw_cmd),
        .fw_arg      (fw_arg),
        .fw_pending  (fw_pending),
        .fw_out_we   (fw_out_we),
        .fw_out_idx  (fw_out_idx),
        .fw_out_byte (fw_out_byte),
        .fw_res_we   (fw_res_we),
        .fw_res_word (fw_res_word),
        .fw_done     (fw_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        host_rd(a, v);
        check(v == exp, req, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic fw_complete();
        @(negedge clk);
        fw_done = 1'b1;
        @(negedge clk);
        fw_done = 1'b0;
    endtask

    task automatic t_reset();
        check(alert == 1'b0, "R1 alert", {31'h0, alert}, 32'h0);
        check(fw_doorbell == 1'b0, "R1 doorbell", {31'h0, fw_doorbell}, 32'h0);
        expect_rd(8'h01, 8'h10, "R1 control");
        expect_rd(8'h02, 8'h00, "R1 status");
        expect_rd(8'h38, 8'h00, "R1 inbound0");
        expect_rd(8'h34, 8'h00, "R1 outbound4");
    endtask

    task automatic t_control();
        logic [7:0] v;
        host_wr(8'h01, 8'h5A);
        host_rd(8'h01, v);
        check(v == 8'h5A, "R2 control rw", {24'h0, v}, 32'h5A);
        @(negedge clk);
        @(negedge clk);
        check(host_rdata == 8'h5A, "R2 rdata hold", {24'h0, host_rdata}, 32'h5A);
        host_wr(8'h01, 8'h10);
    endtask

    task automatic t_inbound();
        host_wr(8'h38, 8'hA5);
        host_wr(8'h39, 8'h78);
        host_wr(8'h3A, 8'h56);
        host_wr(8'h3B, 8'h34);
        host_wr(8'h3C, 8'h12);
        check(fw_pending == 1'b0, "R3 not pending", {31'h0, fw_pending}, 32'h0);
        host_wr(8'h3F, 8'h80);
        check(fw_cmd == 8'hA5, "R3 cmd", {24'h0, fw_cmd}, 32'hA5);
        check(fw_arg == 32'h12345678, "R3 arg order", fw_arg, 32'h12345678);
        check(fw_pending == 1'b1, "R3 pending", {31'h0, fw_pending}, 32'h1);
        expect_rd(8'h3C, 8'h12, "R3 inbound4 readback");
    endtask

    task automatic t_doorbell();
        host_wr(8'h40, 8'h03);
        check(fw_doorbell == 1'b0, "R5 no pulse for 0x03", {31'h0, fw_doorbell}, 32'h0);
        @(negedge clk);
        check(fw_doorbell == 1'b0, "R5 still none", {31'h0, fw_doorbell}, 32'h0);
        host_wr(8'h40, 8'h01);
        check(fw_doorbell == 1'b1, "R5 pulse", {31'h0, fw_doorbell}, 32'h1);
        @(negedge clk);
        check(fw_doorbell == 1'b0, "R5 pulse width", {31'h0, fw_doorbell}, 32'h0);
        expect_rd(8'h40, 8'h00, "R6 swi readback");
    endtask

    task automatic t_outbound();
        @(negedge clk);
        fw_res_we = 1'b1; fw_res_word = 32'hCAFEF00D;
        fw_out_we = 1'b1; fw_out_idx = 3'd0; fw_out_byte = 8'h11;
        @(negedge clk);
        fw_res_we = 1'b0; fw_out_idx = 3'd7; fw_out_byte = 8'h77;
        @(negedge clk);
        fw_out_we = 1'b0;
        expect_rd(8'h30, 8'h11, "R4 out0");
        expect_rd(8'h31, 8'h0D, "R4 word lsb");
        expect_rd(8'h34, 8'hCA, "R4 word msb");
        expect_rd(8'h37, 8'h77, "R4 out7");
        host_wr(8'h31, 8'hFF);
        expect_rd(8'h31, 8'h0D, "R4 host write ignored");
    endtask

    task automatic t_status();
        host_wr(8'h01, 8'h10);
        fw_complete();
        expect_rd(8'h02, 8'h02, "R7 set by done");
        check(alert == 1'b0, "R9 masked", {31'h0, alert}, 32'h0);
        host_wr(8'h01, 8'h00);
        check(alert == 1'b1, "R9 unmasked", {31'h0, alert}, 32'h1);
        host_wr(8'h02, 8'h00);
        expect_rd(8'h02, 8'h02, "R7 write zero no effect");
        check(alert == 1'b1, "R9 alert held", {31'h0, alert}, 32'h1);
        host_wr(8'h02, 8'hFF);
        expect_rd(8'h02, 8'h00, "R7 w1c clear");
        check(alert == 1'b0, "R9 alert drops", {31'h0, alert}, 32'h0);
    endtask

    task automatic t_race();
        fw_complete();
        @(negedge clk);
        host_addr = 8'h02; host_wdata = 8'h02; host_we = 1'b1; fw_done = 1'b1;
        @(negedge clk);
        host_we = 1'b0; fw_done = 1'b0;
        expect_rd(8'h02, 8'h02, "R8 done beats clear");
        host_wr(8'h02, 8'h02);
        expect_rd(8'h02, 8'h00, "R8 later clear");
    endtask

    task automatic t_unmapped();
        host_wr(8'h50, 8'hAA);
        host_wr(8'h00, 8'hFF);
        host_wr(8'h2F, 8'h33);
        expect_rd(8'h50, 8'h00, "R10 read 0x50");
        expect_rd(8'h00, 8'h00, "R10 read 0x00");
        expect_rd(8'h01, 8'h00, "R10 control untouched");
        expect_rd(8'h38, 8'hA5, "R10 inbound untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_control();
        t_inbound();
        t_doorbell();
        t_outbound();
        t_status();
        t_race();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule